// File: doc/BRIEF.md
# Port-Pair Bypass Relay Controller

This block decides whether one pair of Ethernet ports is bridged straight through by a relay (bypass) or handed to the switching silicon (normal). A host programs it over a small byte-addressed register bus that models a two-wire management target. Each request carries an 8-bit device byte: bits 7:1 select the target, and bit 0 gives the direction (0 = write, 1 = read). A strap input picks one of two target addresses, so two copies can share the bus.

Three inputs decide the relay state: the system power flag, a watchdog-expiry level, and the programmed registers. There are separate settings for the powered-off case, the powered-on case and the watchdog-asserted case. The block can also turn a new watchdog assertion into one active-low reset pulse of fixed length. The pulse length is a clock-cycle count set by a parameter; the default equals 100 ms at 250 MHz.

Top module: `bypass_relay_ctrl`

## Requirements
- R1: The target responds only when device-byte bits 7:1 equal 0x68 >> 1 with `strap_sel` = 0, or 0x6A >> 1 with `strap_sel` = 1. Bit 0 of the device byte selects write (0) or read (1). A request to any other address gets no `bus_ack`, and a write to such an address changes no register.
- R2: Register 0x22, bit 0, is the power-on setting (1 = bypass, 0 = normal). While `sys_power_on` = 1 and no watchdog override applies, `bypass_on` follows this bit.
- R3: Register 0x24, bit 0, is the power-off setting. While `sys_power_on` = 0, `bypass_on` follows this bit, whatever the watchdog and its registers hold.
- R4: Register 0x26, bit 0, enables the reset pulse. When it is 1, a rising edge of `wdt_expired` drives `rst_out_n` low for exactly PULSE_CYCLES cycles, starting one cycle after the edge. When it is 0, the watchdog never pulls `rst_out_n` low.
- R5: Register 0x26, bit 1, enables the watchdog override. Bits 7:2 of register 0x26 read as 0. While bit 1 is 0, registers 0x28 and 0x2A have no effect on `bypass_on`.
- R6: Register 0x28, bit 0, enables following. When `sys_power_on` = 1, `wdt_expired` = 1 and 0x26 bit 1 = 1, `bypass_on` takes the value from register 0x2A only if this bit is 1. If it is 0, the power-on setting stays in force.
- R7: Register 0x2A, bit 0, is the relay state applied while the watchdog override is active (1 = bypass, 0 = normal).
- R8: Each watchdog assertion produces at most one pulse. Holding `wdt_expired` high gives no further pulse, and a new rising edge that arrives while a pulse is running is ignored.
- R9: Reading an unimplemented register address returns 0x00, and writing to it changes nothing. Bits 7:1 of registers 0x22, 0x24, 0x28 and 0x2A read as 0.
- R10: After reset, every register bit is 0, `bypass_on` = 0, `rst_out_n` = 1 and `bus_ack` = 0.
- R11: `bus_ack` and `bus_rdata` are registered and appear in the cycle after the request. `bypass_on` is registered and reflects inputs and registers one cycle after they change. `bus_rdata` is 0x00 whenever there is no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| strap_sel | input | 1 | Selects the alternate target address |
| bus_valid | input | 1 | A request is present this cycle |
| bus_dev | input | 8 | Device byte: bits 7:1 are the address, bit 0 is the direction (1 = read) |
| bus_reg | input | 8 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_ack | output | 1 | Request accepted by this target |
| bus_rdata | output | 8 | Read data |
| sys_power_on | input | 1 | 1 while the system is powered |
| wdt_expired | input | 1 | Watchdog expiry level |
| bypass_on | output | 1 | 1 = relay in bypass, 0 = normal |
| rst_out_n | output | 1 | Active-low timed reset pulse |

## Verification
A wrong setting bit or a wrong priority shows up on `bypass_on` one cycle after the input change that exposes it. A full sweep over every combination of the five setting bits, power and watchdog therefore catches it within a few cycles. A counter that is stuck, loaded with the wrong value or retriggered shows up as a low time on `rst_out_n` that is wrong by at least one cycle, or as a second pulse. A wrong address decode or a wrong reserved-bit mask shows up as a missing or spurious `bus_ack`, or as wrong `bus_rdata`, one cycle after the request.

// File: rtl/bypass_relay_ctrl.sv
module bypass_relay_ctrl #(
  parameter int unsigned PULSE_CYCLES = 25_000_000,
  parameter logic [7:0]  BASE_ADDR    = 8'h68,
  parameter logic [7:0]  ALT_ADDR     = 8'h6A
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       strap_sel,
  input  logic       bus_valid,
  input  logic [7:0] bus_dev,
  input  logic [7:0] bus_reg,
  input  logic [7:0] bus_wdata,
  output logic       bus_ack,
  output logic [7:0] bus_rdata,
  input  logic       sys_power_on,
  input  logic       wdt_expired,
  output logic       bypass_on,
  output logic       rst_out_n
);
  localparam int unsigned CW = $clog2(PULSE_CYCLES + 1);

  logic          byp_pwr_on, byp_pwr_off, wdt_follow, wdt_state;
  logic [1:0]    wdt_ctl;
  logic          wdt_d;
  logic [CW-1:0] pulse_cnt;
  logic [6:0]    my_id;
  logic          hit, wr, rd, sel_next;
  logic [7:0]    rd_mux;

  assign my_id = strap_sel ? ALT_ADDR[7:1] : BASE_ADDR[7:1];
  assign hit   = bus_valid && (bus_dev[7:1] == my_id);
  assign wr    = hit && !bus_dev[0];
  assign rd    = hit && bus_dev[0];

  always_comb begin
    case (bus_reg)
      8'h22:   rd_mux = {7'b0, byp_pwr_on};
      8'h24:   rd_mux = {7'b0, byp_pwr_off};
      8'h26:   rd_mux = {6'b0, wdt_ctl};
      8'h28:   rd_mux = {7'b0, wdt_follow};
      8'h2A:   rd_mux = {7'b0, wdt_state};
      default: rd_mux = 8'h00;
    endcase
  end

  always_comb begin
    if (!sys_power_on)                            sel_next = byp_pwr_off;
    else if (wdt_expired && wdt_ctl[1] && wdt_follow) sel_next = wdt_state;
    else                                          sel_next = byp_pwr_on;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      byp_pwr_on  <= 1'b0;
      byp_pwr_off <= 1'b0;
      wdt_ctl     <= 2'b00;
      wdt_follow  <= 1'b0;
      wdt_state   <= 1'b0;
    end else if (wr) begin
      case (bus_reg)
        8'h22: byp_pwr_on  <= bus_wdata[0];
        8'h24: byp_pwr_off <= bus_wdata[0];
        8'h26: wdt_ctl     <= bus_wdata[1:0];
        8'h28: wdt_follow  <= bus_wdata[0];
        8'h2A: wdt_state   <= bus_wdata[0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_ack   <= 1'b0;
      bus_rdata <= 8'h00;
      bypass_on <= 1'b0;
      wdt_d     <= 1'b0;
      pulse_cnt <= '0;
    end else begin
      bus_ack   <= hit;
      bus_rdata <= rd ? rd_mux : 8'h00;
      bypass_on <= sel_next;
      wdt_d     <= wdt_expired;
      if (pulse_cnt != '0)
        pulse_cnt <= pulse_cnt - 1'b1;
      else if (wdt_expired && !wdt_d && wdt_ctl[0])
        pulse_cnt <= CW'(PULSE_CYCLES);
    end
  end

  assign rst_out_n = (pulse_cnt == '0);
endmodule

module bypass_relay_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic bus_valid,
  input logic bus_ack,
  input logic sys_power_on,
  input logic wdt_expired,
  input logic bypass_on,
  input logic rst_out_n,
  input logic pwr_on_bit,
  input logic pwr_off_bit,
  input logic wdt_byp_en
);
  // R3
  pwroff_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sys_power_on |=> bypass_on == $past(pwr_off_bit));
  // R5
  override_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_power_on && !wdt_byp_en) |=> bypass_on == $past(pwr_on_bit));
  // R11
  ack_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ack |-> $past(bus_valid));
  // R4
  pulse_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rst_out_n) |-> $past(wdt_expired));
  // R2
  pwron_no_wdt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_power_on && !wdt_expired) |=> bypass_on == $past(pwr_on_bit));
endmodule

bind bypass_relay_ctrl bypass_relay_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_ack(bus_ack),
  .sys_power_on(sys_power_on), .wdt_expired(wdt_expired),
  .bypass_on(bypass_on), .rst_out_n(rst_out_n),
  .pwr_on_bit(byp_pwr_on), .pwr_off_bit(byp_pwr_off), .wdt_byp_en(wdt_ctl[1])
);

// File: tb/bypass_relay_ctrl_bench.sv
module bypass_relay_ctrl_bench;
  localparam int unsigned PW = 10;

  logic clk = 1'b0, rst_n = 1'b0, strap_sel = 1'b0, bus_valid = 1'b0;
  logic [7:0] bus_dev = 8'h00, bus_reg = 8'h00, bus_wdata = 8'h00;
  logic bus_ack, bypass_on, rst_out_n;
  logic [7:0] bus_rdata;
  logic sys_power_on = 1'b0, wdt_expired = 1'b0;
  int total = 0, bad = 0;
  bit done = 1'b0;
  logic [7:0] rv;
  logic ak;

  always #2 clk = ~clk;

  bypass_relay_ctrl #(.PULSE_CYCLES(PW)) u_bypass_relay_ctrl (
    .clk(clk), .rst_n(rst_n), .strap_sel(strap_sel), .bus_valid(bus_valid),
    .bus_dev(bus_dev), .bus_reg(bus_reg), .bus_wdata(bus_wdata),
    .bus_ack(bus_ack), .bus_rdata(bus_rdata), .sys_power_on(sys_power_on),
    .wdt_expired(wdt_expired), .bypass_on(bypass_on), .rst_out_n(rst_out_n));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic [7:0] dev, input logic [7:0] ra, input logic [7:0] wd);
    @(negedge clk);
    bus_valid = 1'b1; bus_dev = dev; bus_reg = ra; bus_wdata = wd;
    @(posedge clk);
    @(negedge clk);
    ak = bus_ack; rv = bus_rdata;
    bus_valid = 1'b0;
  endtask

  task automatic step;
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [7:0] own(input bit rd);
    return (strap_sel ? 8'h6A : 8'h68) | {7'b0, rd};
  endfunction

  initial begin
    #(4 * 200000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk(bypass_on == 1'b0, "R10 bypass", bypass_on, 0);
    chk(rst_out_n == 1'b1, "R10 rst_out_n", rst_out_n, 1);
    chk(bus_ack == 1'b0, "R10 ack", bus_ack, 0);
    foreach (rv[i]) ;
    for (int a = 8'h22; a <= 8'h2A; a += 2) begin
      xfer(own(1), a[7:0], 8'h00);
      chk(ak && rv == 8'h00, "R10 reg reset", rv, 0);
    end

    // R9 unimplemented and reserved bits
    xfer(own(0), 8'h23, 8'hFF);
    xfer(own(1), 8'h23, 8'h00);
    chk(rv == 8'h00, "R9 unimpl read", rv, 0);
    xfer(own(1), 8'h22, 8'h00);
    chk(rv == 8'h00, "R9 unimpl write no effect", rv, 0);
    xfer(own(0), 8'h22, 8'hFE);
    xfer(own(1), 8'h22, 8'h00);
    chk(rv == 8'h00, "R9 reserved bits", rv, 0);
    xfer(own(0), 8'h26, 8'hFC);
    xfer(own(1), 8'h26, 8'h00);
    chk(rv == 8'h00, "R5 reserved bits 7:2", rv, 0);
    // R11 rdata zero on write
    xfer(own(0), 8'h22, 8'h01);
    chk(ak && rv == 8'h00, "R11 write rdata zero", rv, 0);
    xfer(own(1), 8'h22, 8'h00);
    chk(rv == 8'h01, "R2 readback", rv, 1);

    // R1 address decode, both strap values
    for (int s = 0; s < 2; s++) begin
      strap_sel = s[0];
      xfer(s ? 8'h68 : 8'h6A, 8'h24, 8'h01);
      chk(ak == 1'b0, "R1 foreign no ack", ak, 0);
      xfer(s ? 8'h69 : 8'h6B, 8'h24, 8'h00);
      chk(ak == 1'b0 && rv == 8'h00, "R1 foreign read", rv, 0);
      xfer(own(1), 8'h24, 8'h00);
      chk(ak && rv == 8'h00, "R1 foreign write ignored", rv, 0);
      xfer(8'h50, 8'h22, 8'h00);
      chk(ak == 1'b0, "R1 other addr", ak, 0);
    end
    strap_sel = 1'b0;

    // R2 R3 R5 R6 R7 sweep
    for (int i = 0; i < 128; i++) begin
      logic on_b, off_b, en_b, fol_b, st_b, pw, wd, exp_b;
      on_b = i[0]; off_b = i[1]; en_b = i[2]; fol_b = i[3]; st_b = i[4];
      pw = i[5]; wd = i[6];
      xfer(own(0), 8'h22, {7'b0, on_b});
      xfer(own(0), 8'h24, {7'b0, off_b});
      xfer(own(0), 8'h26, {6'b0, en_b, 1'b0});
      xfer(own(0), 8'h28, {7'b0, fol_b});
      xfer(own(0), 8'h2A, {7'b0, st_b});
      sys_power_on = pw; wdt_expired = wd;
      step();
      exp_b = !pw ? off_b : ((wd && en_b && fol_b) ? st_b : on_b);
      chk(bypass_on == exp_b, !pw ? "R3 sweep" : (wd && en_b ? (fol_b ? "R7 sweep" : "R6 sweep") : "R5 sweep"),
          bypass_on, exp_b);
      chk(rst_out_n == 1'b1, "R4 disabled no pulse", rst_out_n, 1);
      wdt_expired = 1'b0;
    end
    xfer(own(1), 8'h26, 8'h00);
    chk(rv == 8'h02, "R5 readback", rv, 2);
    // R11 one-cycle bypass latency
    xfer(own(0), 8'h22, 8'h00);
    xfer(own(0), 8'h24, 8'h01);
    sys_power_on = 1'b1;
    step();
    chk(bypass_on == 1'b0, "R11 settle", bypass_on, 0);
    @(negedge clk);
    sys_power_on = 1'b0;
    @(posedge clk); #1;
    chk(bypass_on == 1'b1, "R11 latency", bypass_on, 1);
    sys_power_on = 1'b1;

    // R4 pulse length
    xfer(own(0), 8'h26, 8'h01);
    begin
      int lows = 0;
      @(negedge clk); wdt_expired = 1'b1;
      step();
      chk(rst_out_n == 1'b0, "R4 pulse start", rst_out_n, 0);
      lows = 1;
      for (int k = 0; k < PW + 20; k++) begin
        if (k == 2) wdt_expired = 1'b0;
        if (k == 4) wdt_expired = 1'b1;
        step();
        if (!rst_out_n) lows++;
      end
      chk(lows == PW, "R4 pulse width", lows, PW);
      chk(lows == PW, "R8 retrigger ignored", lows, PW);
      lows = 0;
      for (int k = 0; k < PW + 5; k++) begin
        step();
        if (!rst_out_n) lows++;
      end
      chk(lows == 0, "R8 held high no repeat", lows, 0);
      // new assertion gives a new pulse
      @(negedge clk); wdt_expired = 1'b0;
      step();
      wdt_expired = 1'b1;
      lows = 0;
      for (int k = 0; k < PW + 5; k++) begin
        step();
        if (!rst_out_n) lows++;
      end
      chk(lows == PW, "R8 second assertion", lows, PW);
      // disabled
      wdt_expired = 1'b0;
      xfer(own(0), 8'h26, 8'h00);
      @(negedge clk); wdt_expired = 1'b1;
      lows = 0;
      for (int k = 0; k < PW + 5; k++) begin
        step();
        if (!rst_out_n) lows++;
      end
      chk(lows == 0, "R4 disabled", lows, 0);
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule